// File: doc/BRIEF.md
# Aligned Protected Memory Access Checker

This block sits between the processor and storage and checks every access request before it reaches memory. Each request brings a byte address, an access size (byte, halfword, word, doubleword or instruction fetch), a write flag, the current privilege mode, the number of 512-word protection modules and a choice of implemented memory size. One clock later the block gives a verdict: pass, or fault with a cause code. A fault also pulses a program-interrupt request.

Addresses name the leftmost byte of the data. Alignment is checked first. The range check then uses the last byte the access touches, so a multi-byte access that runs past the top of memory is caught. The protection check applies only to writes made in unprivileged mode, against a region that starts at address zero. A range fault and a protection fault both raise an invalid-address indication.

Top module: `acc_chk_top`

## Requirements
- R1: A byte access (size code 0) is never misaligned. A halfword access (size code 1) at an odd address gives cause code 1 (misaligned).
- R2: Word (code 2), doubleword (code 3) and instruction fetch (code 4) accesses give cause 1 when address bits [1:0] are nonzero. A doubleword at an address that is 4 modulo 8 passes alignment.
- R3: Size codes 5, 6 and 7 always give cause 1.
- R4: Cause code 2 (out of range) is given when the last byte touched (address plus size in bytes minus one, computed without wrap) is above the top byte. The top byte is 0x1FFFF when the memory-size input is 0 (32K words) and 0x3FFFF when it is 1 (64K words). Byte counts are 1, 2, 4, 8 and 4 for codes 0 to 4.
- R5: Cause code 3 (protection) is given for an unprivileged write, of any size except fetch, whose address is below the module count times 2048.
- R6: A module count of 0 is treated as 1, and a count above 32 is treated as 32.
- R7: Privileged writes, all reads, and instruction fetches (whatever the write flag) never give cause 3.
- R8: When several faults apply, misaligned outranks out of range, and out of range outranks protection.
- R9: The verdict appears on the cycle after a request (vld_o high for exactly that cycle). A cycle with no request gives vld_o, fault_o, bad_addr_o and pgm_irq_o all 0 and cause_o 0 on the next cycle.
- R10: With the verdict, fault_o and pgm_irq_o are 1 exactly when the cause is nonzero. bad_addr_o is 1 exactly when the cause is 2 or 3.
- R11: While rst_n is low at a clock edge, all outputs are 0 after that edge, whatever the request inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request present this cycle |
| addr_i | input | 20 | Byte address of the leftmost byte |
| size_i | input | 3 | Access size code (0 byte, 1 halfword, 2 word, 3 doubleword, 4 fetch) |
| wr_i | input | 1 | 1 for a write |
| priv_i | input | 1 | 1 when the processor is privileged |
| prot_mods_i | input | 6 | Protected-region size in 512-word modules |
| mem_large_i | input | 1 | 0 for 32K words of memory, 1 for 64K words |
| vld_o | output | 1 | Verdict valid |
| fault_o | output | 1 | Request faulted |
| cause_o | output | 2 | 0 none, 1 misaligned, 2 out of range, 3 protection |
| bad_addr_o | output | 1 | Invalid address (out of range or protection) |
| pgm_irq_o | output | 1 | Program-interrupt request pulse |

## Verification
The block holds only the verdict register, so any internal error shows at the ports on the cycle right after the request that exposes it. A wrong protection limit shows as a wrong cause at the first unprivileged write just inside or just outside the region edge. A wrong span or top value shows at the accesses that end exactly at, or one byte past, the top of memory. A priority mistake shows as cause 2 or 3 where cause 1 was due. Register faults show as a verdict that is missing, late, or left over when no request is present.

// File: rtl/acc_chk_pkg.sv
// Package: shared encodings for the access checker.
// Assumes size and cause codes stay fixed. Neighbouring logic decodes them.
package acc_chk_pkg;

    // Access size codes as seen on the request
    localparam logic [2:0] SZ_BYTE  = 3'd0;
    localparam logic [2:0] SZ_HALF  = 3'd1;
    localparam logic [2:0] SZ_WORD  = 3'd2;
    localparam logic [2:0] SZ_DWORD = 3'd3;
    localparam logic [2:0] SZ_FETCH = 3'd4;

    // Fault cause codes on the verdict
    typedef enum logic [1:0] {
        CZ_NONE  = 2'd0,
        CZ_ALIGN = 2'd1,
        CZ_RANGE = 2'd2,
        CZ_PROT  = 2'd3
    } fault_cause_e;

    // Number of bytes an access of the given size touches
    function automatic logic [3:0] span_bytes(input logic [2:0] sz);
        case (sz)
            SZ_BYTE:  span_bytes = 4'd1;
            SZ_HALF:  span_bytes = 4'd2;
            SZ_WORD:  span_bytes = 4'd4;
            SZ_DWORD: span_bytes = 4'd8;
            SZ_FETCH: span_bytes = 4'd4;
            default:  span_bytes = 4'd1;
        endcase
    endfunction

endpackage

// File: rtl/acc_align_chk.sv
// Alignment check: flags an access whose address does not suit its size.
// Assumes only the two low address bits matter. Doublewords need word alignment only.
module acc_align_chk
    import acc_chk_pkg::*;
(
    input  logic [1:0] lsb_i,
    input  logic [2:0] size_i,
    output logic       bad_o
);

    // Decide misalignment from the size and the low address bits
    always_comb begin
        case (size_i)
            SZ_BYTE:                    bad_o = 1'b0;
            SZ_HALF:                    bad_o = lsb_i[0];
            SZ_WORD, SZ_DWORD, SZ_FETCH: bad_o = |lsb_i;
            default:                    bad_o = 1'b1;
        endcase
    end

    // Guard the alignment rules at the boundary of this module
    always_comb begin
        // R1
        byte_any_chk: assert (!(size_i == SZ_BYTE && bad_o));
        // R2
        dword_word_ok_chk: assert (!(size_i == SZ_DWORD && lsb_i == 2'b00 && bad_o));
    end

endmodule

// File: rtl/acc_range_chk.sv
// Range check: flags an access whose last byte lies above the implemented top.
// Assumes memory is two or four storage units. The sum is kept one bit wider so it cannot wrap.
module acc_range_chk
    import acc_chk_pkg::*;
#(
    parameter int ADDR_W     = 20,
    parameter int UNIT_WORDS = 16384,
    parameter int WORD_BYTES = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic              large_i,
    output logic              bad_o
);

    localparam int UNIT_BYTES = UNIT_WORDS * WORD_BYTES;
    localparam logic [ADDR_W:0] TOP_SMALL = (ADDR_W+1)'(2 * UNIT_BYTES - 1);
    localparam logic [ADDR_W:0] TOP_LARGE = (ADDR_W+1)'(4 * UNIT_BYTES - 1);

    logic [ADDR_W:0] last_c;
    logic [ADDR_W:0] top_c;

    // Compute the last byte touched and compare it with the configured top
    always_comb begin
        top_c  = large_i ? TOP_LARGE : TOP_SMALL;
        last_c = {1'b0, addr_i} + (ADDR_W+1)'(span_bytes(size_i)) - (ADDR_W+1)'(1);
        bad_o  = last_c > top_c;
    end

    // Guard: a start address already past the top must be flagged
    always_comb begin
        // R4
        start_past_top_chk: assert (!({1'b0, addr_i} > top_c) || bad_o);
    end

endmodule

// File: rtl/acc_prot_chk.sv
// Protection check: flags unprivileged writes into the low protected region.
// Assumes the region starts at zero and grows in fixed modules. The count is clamped to 1..MAX_MODULES.
module acc_prot_chk
    import acc_chk_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int MODULE_WORDS = 512,
    parameter int WORD_BYTES   = 4,
    parameter int MAX_MODULES  = 32,
    parameter int CNT_W        = 6
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic              wr_i,
    input  logic              priv_i,
    input  logic [CNT_W-1:0]  mods_i,
    output logic              viol_o
);

    localparam int MODULE_BYTES = MODULE_WORDS * WORD_BYTES;
    localparam logic [ADDR_W:0] LIMIT_MIN = (ADDR_W+1)'(MODULE_BYTES);
    localparam logic [ADDR_W:0] LIMIT_MAX = (ADDR_W+1)'(MAX_MODULES * MODULE_BYTES);

    logic [CNT_W-1:0] cnt_c;
    logic [ADDR_W:0]  limit_c;
    logic             store_c;

    // Clamp the module count into its legal range
    always_comb begin
        if (mods_i == '0)
            cnt_c = CNT_W'(1);
        else if (int'(mods_i) > MAX_MODULES)
            cnt_c = CNT_W'(MAX_MODULES);
        else
            cnt_c = mods_i;
    end

    // Form the byte limit and test for an unprivileged store below it
    always_comb begin
        limit_c = (ADDR_W+1)'(int'(cnt_c) * MODULE_BYTES);
        store_c = wr_i && (size_i != SZ_FETCH);
        viol_o  = store_c && !priv_i && ({1'b0, addr_i} < limit_c);
    end

    // Guard the protection rules at this module's boundary
    always_comb begin
        // R7
        viol_only_user_store_chk: assert (!viol_o || (wr_i && !priv_i && size_i != SZ_FETCH));
        // R6
        limit_in_bounds_chk: assert (limit_c >= LIMIT_MIN && limit_c <= LIMIT_MAX);
    end

endmodule

// File: rtl/acc_chk_top.sv
// Top level: combines the alignment, range and protection checks into a registered verdict.
// Assumes one request per cycle at most. The verdict appears one cycle after the request.
// Cause priority: misaligned, then out of range, then protection.
module acc_chk_top
    import acc_chk_pkg::*;
#(
    parameter int ADDR_W       = 20,
    parameter int UNIT_WORDS   = 16384,
    parameter int MODULE_WORDS = 512,
    parameter int WORD_BYTES   = 4,
    parameter int MAX_MODULES  = 32,
    localparam int CNT_W       = $clog2(MAX_MODULES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic              wr_i,
    input  logic              priv_i,
    input  logic [CNT_W-1:0]  prot_mods_i,
    input  logic              mem_large_i,
    output logic              vld_o,
    output logic              fault_o,
    output logic [1:0]        cause_o,
    output logic              bad_addr_o,
    output logic              pgm_irq_o
);

    logic         mis_c;
    logic         rng_c;
    logic         prot_c;
    fault_cause_e cause_c;

    acc_align_chk u_align (
        .lsb_i  (addr_i[1:0]),
        .size_i (size_i),
        .bad_o  (mis_c)
    );

    acc_range_chk #(
        .ADDR_W     (ADDR_W),
        .UNIT_WORDS (UNIT_WORDS),
        .WORD_BYTES (WORD_BYTES)
    ) u_range (
        .addr_i  (addr_i),
        .size_i  (size_i),
        .large_i (mem_large_i),
        .bad_o   (rng_c)
    );

    acc_prot_chk #(
        .ADDR_W       (ADDR_W),
        .MODULE_WORDS (MODULE_WORDS),
        .WORD_BYTES   (WORD_BYTES),
        .MAX_MODULES  (MAX_MODULES),
        .CNT_W        (CNT_W)
    ) u_prot (
        .addr_i (addr_i),
        .size_i (size_i),
        .wr_i   (wr_i),
        .priv_i (priv_i),
        .mods_i (prot_mods_i),
        .viol_o (prot_c)
    );

    // Pick the highest-priority fault cause
    always_comb begin
        if (mis_c)
            cause_c = CZ_ALIGN;
        else if (rng_c)
            cause_c = CZ_RANGE;
        else if (prot_c)
            cause_c = CZ_PROT;
        else
            cause_c = CZ_NONE;
    end

    // Register the verdict for one cycle after each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_o      <= 1'b0;
            fault_o    <= 1'b0;
            cause_o    <= 2'd0;
            bad_addr_o <= 1'b0;
            pgm_irq_o  <= 1'b0;
        end else begin
            vld_o      <= req_i;
            fault_o    <= req_i && (mis_c || rng_c || prot_c);
            cause_o    <= req_i ? cause_c : CZ_NONE;
            bad_addr_o <= req_i && !mis_c && (rng_c || prot_c);
            pgm_irq_o  <= req_i && (mis_c || rng_c || prot_c);
        end
    end

    // R9
    idle_no_verdict_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> (!vld_o && cause_o == 2'd0 && !pgm_irq_o));

    // R8
    align_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && mis_c) |=> (vld_o && cause_o == 2'd1));

    // R10
    irq_with_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pgm_irq_o |-> (vld_o && fault_o && cause_o != 2'd0));

    // R10
    bad_addr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bad_addr_o |-> (cause_o == 2'd2 || cause_o == 2'd3));

    // R8
    range_over_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !mis_c && rng_c) |=> (cause_o == 2'd2));

endmodule

// File: tb/test_acc_chk_top.sv
// Bench: a vector table walked by one loop, then directed reset and timing tests.
module test_acc_chk_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_i;
    logic [19:0] addr_i;
    logic [2:0]  size_i;
    logic        wr_i;
    logic        priv_i;
    logic [5:0]  prot_mods_i;
    logic        mem_large_i;
    logic        vld_o;
    logic        fault_o;
    logic [1:0]  cause_o;
    logic        bad_addr_o;
    logic        pgm_irq_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    acc_chk_top i_acc_chk_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .addr_i      (addr_i),
        .size_i      (size_i),
        .wr_i        (wr_i),
        .priv_i      (priv_i),
        .prot_mods_i (prot_mods_i),
        .mem_large_i (mem_large_i),
        .vld_o       (vld_o),
        .fault_o     (fault_o),
        .cause_o     (cause_o),
        .bad_addr_o  (bad_addr_o),
        .pgm_irq_o   (pgm_irq_o)
    );

    // Vector: {addr, size, wr, priv, mods, large, expected cause}
    localparam int NV = 28;
    localparam logic [33:0] VEC [NV] = '{
        {20'h00003, 3'd0, 1'b0, 1'b0, 6'd1,  1'b1, 2'd0},
        {20'h00005, 3'd1, 1'b0, 1'b0, 6'd1,  1'b1, 2'd1},
        {20'h00006, 3'd1, 1'b0, 1'b0, 6'd1,  1'b1, 2'd0},
        {20'h00102, 3'd2, 1'b0, 1'b0, 6'd1,  1'b1, 2'd1},
        {20'h00804, 3'd3, 1'b0, 1'b0, 6'd1,  1'b1, 2'd0},
        {20'h00801, 3'd4, 1'b0, 1'b0, 6'd1,  1'b1, 2'd1},
        {20'h00000, 3'd5, 1'b0, 1'b0, 6'd1,  1'b1, 2'd1},
        {20'h00000, 3'd7, 1'b0, 1'b1, 6'd1,  1'b1, 2'd1},
        {20'h3FFFF, 3'd0, 1'b0, 1'b0, 6'd1,  1'b1, 2'd0},
        {20'h40000, 3'd0, 1'b0, 1'b0, 6'd1,  1'b1, 2'd2},
        {20'h20000, 3'd0, 1'b0, 1'b0, 6'd1,  1'b0, 2'd2},
        {20'h1FFFC, 3'd2, 1'b0, 1'b0, 6'd1,  1'b0, 2'd0},
        {20'h1FFFC, 3'd3, 1'b0, 1'b0, 6'd1,  1'b0, 2'd2},
        {20'h3FFF8, 3'd3, 1'b0, 1'b0, 6'd1,  1'b1, 2'd0},
        {20'h007FC, 3'd2, 1'b1, 1'b0, 6'd1,  1'b1, 2'd3},
        {20'h00800, 3'd2, 1'b1, 1'b0, 6'd1,  1'b1, 2'd0},
        {20'h0FFFF, 3'd0, 1'b1, 1'b0, 6'd32, 1'b1, 2'd3},
        {20'h10000, 3'd0, 1'b1, 1'b0, 6'd32, 1'b1, 2'd0},
        {20'h007FF, 3'd0, 1'b1, 1'b0, 6'd0,  1'b1, 2'd3},
        {20'h00800, 3'd0, 1'b1, 1'b0, 6'd0,  1'b1, 2'd0},
        {20'h10000, 3'd0, 1'b1, 1'b0, 6'd40, 1'b1, 2'd0},
        {20'h0FFFC, 3'd2, 1'b1, 1'b0, 6'd40, 1'b1, 2'd3},
        {20'h00000, 3'd2, 1'b1, 1'b1, 6'd32, 1'b1, 2'd0},
        {20'h00010, 3'd2, 1'b0, 1'b0, 6'd32, 1'b1, 2'd0},
        {20'h00010, 3'd4, 1'b1, 1'b0, 6'd32, 1'b1, 2'd0},
        {20'h00001, 3'd1, 1'b1, 1'b0, 6'd32, 1'b1, 2'd1},
        {20'h40002, 3'd2, 1'b0, 1'b0, 6'd1,  1'b1, 2'd1},
        {20'hFFFFC, 3'd3, 1'b1, 1'b0, 6'd32, 1'b1, 2'd2}
    };

    // Requirement tag that a table row exercises
    function automatic string tag_of(input int i);
        if (i < 3)       tag_of = "R1";
        else if (i < 6)  tag_of = "R2";
        else if (i < 8)  tag_of = "R3";
        else if (i < 14) tag_of = "R4";
        else if (i < 18) tag_of = "R5";
        else if (i < 22) tag_of = "R6";
        else if (i < 25) tag_of = "R7";
        else if (i < 27) tag_of = "R8";
        else             tag_of = "R4";
    endfunction

    // Compare one value and log a failure line
    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Drive one request onto the inputs
    task automatic drive(input logic [33:0] v);
        req_i       = 1'b1;
        addr_i      = v[33:14];
        size_i      = v[13:11];
        wr_i        = v[10];
        priv_i      = v[9];
        prot_mods_i = v[8:3];
        mem_large_i = v[2];
    endtask

    // Check all verdict outputs against one expected cause
    task automatic check_verdict(input string tag, input logic [1:0] c);
        check({tag, " R9 vld"},    32'(vld_o),      32'd1);
        check({tag, " cause"},     32'(cause_o),    32'(c));
        check({tag, " R10 fault"}, 32'(fault_o),    32'(c != 2'd0));
        check({tag, " R10 bad"},   32'(bad_addr_o), 32'(c >= 2'd2));
        check({tag, " R10 irq"},   32'(pgm_irq_o),  32'(c != 2'd0));
    endtask

    // Check that every output is at rest
    task automatic check_quiet(input string tag);
        check({tag, " vld"},   32'(vld_o),      32'd0);
        check({tag, " cause"}, 32'(cause_o),    32'd0);
        check({tag, " fault"}, 32'(fault_o),    32'd0);
        check({tag, " bad"},   32'(bad_addr_o), 32'd0);
        check({tag, " irq"},   32'(pgm_irq_o),  32'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R9 watchdog actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    // Main stimulus sequence
    initial begin
        rst_n = 1'b0;
        drive(VEC[1]);
        repeat (3) @(negedge clk);
        // R11: reset holds outputs low even with a faulting request
        check_quiet("R11 reset");

        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i]);
            @(negedge clk);
            check_verdict(tag_of(i), VEC[i][1:0]);
        end

        // R9: idle cycle clears the verdict
        req_i = 1'b0;
        @(negedge clk);
        check_quiet("R9 idle");

        // R10: interrupt is a one-cycle pulse on a fault
        drive(VEC[14]);
        @(negedge clk);
        check("R10 irq pulse high", 32'(pgm_irq_o), 32'd1);
        req_i = 1'b0;
        @(negedge clk);
        check("R10 irq pulse low", 32'(pgm_irq_o), 32'd0);
        check("R9 vld after idle", 32'(vld_o), 32'd0);

        // R9: back-to-back requests give back-to-back verdicts
        drive(VEC[9]);
        @(negedge clk);
        check("R9 first of pair", 32'(cause_o), 32'd2);
        drive(VEC[0]);
        @(negedge clk);
        check_verdict("R9 second of pair", 2'd0);

        // R11: reset taken mid-stream drops a pending verdict
        drive(VEC[3]);
        rst_n = 1'b0;
        @(negedge clk);
        check_quiet("R11 mid reset");
        rst_n = 1'b1;
        req_i = 1'b0;
        @(negedge clk);
        check_quiet("R11 after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule